// File: doc/BRIEF.md
# Variable-Density Sparse Dot-Product Engine

This engine multiplies a dense vector of signed 8-bit features by a weight matrix whose rows have been thinned out, and it never spends a cycle on a removed row. The weight matrix is cut into groups of `M` consecutive rows. For each group, only the rows that still carry weight are stored. Each stored row comes with a small position tag that says which of the `M` rows it was. The number of stored rows `N` is written in a header word in front of the group, and it can be different for every group.

The engine takes words from a stream. It reads a header, then takes exactly `N` row words. For each row word it forms a feature-buffer address from the group number and the position tag, and it reads that feature in the same cycle. Every output lane multiplies the feature by its own 8-bit weight from the row word and adds the product to a saturating signed accumulator. A group therefore costs one header cycle plus `N` row cycles, where a dense pass would cost `M` row cycles.

A start pulse clears the accumulators and latches the number of groups. A single-cycle done pulse, together with a result-valid pulse, marks the cycle in which the final sums can be read.

Top module: `spmac_engine`

## Requirements
- R1: Each of the `LANES` lanes keeps the signed sum of products of an 8-bit signed weight and an 8-bit signed feature. For lane l, the result equals the dot product of the feature vector with column l of the weight matrix, with pruned rows counted as zero.
- R2: The stream carries one header word for each group, followed by that group's row words. In a header, `s_data[NW-1:0]` is the unsigned count N. In a row word, lane l takes its weight from `s_data[8l+7:8l]`, and `s_idx` gives the row's position inside its group.
- R3: A row word with position i in group g (groups counted from 0) fetches the feature at address g*M+i. `feat_addr` is driven combinationally, and `feat_data` is consumed in the same cycle.
- R4: N may differ from group to group. Exactly N row words are consumed after each header. With `s_valid` held high, `busy` stays high for (number of groups + sum of N) cycles.
- R5: A group whose header gives N = 0 consumes only its header word and takes one cycle.
- R6: A header count greater than M is treated as M.
- R7: `s_ready` is high exactly while `busy` is high. A cycle with `s_valid` low changes neither the accumulators nor the progress through the stream.
- R8: Each accumulator is `ACC_W` bits wide (32 by default). An addition that would overflow clamps the value to the largest or smallest representable value.
- R9: A start pulse while idle clears all accumulators and latches `num_groups`. With `num_groups` = 0, the engine completes in the next cycle and reports zero sums.
- R10: `done` and `res_valid` rise together for a single cycle, the cycle after the last stream word is accepted. `res_data` then holds the final sums until the next accepted start.
- R11: A start pulse while `busy` is high is ignored. It neither clears the accumulators nor changes the group count.
- R12: Asserting `rst_n` low forces the engine idle, with `busy`, `done` and `res_valid` low and the accumulators zero. Reset is applied asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new pass (ignored while busy) |
| num_groups | input | GW | Number of row groups in the pass |
| busy | output | 1 | Pass in progress |
| s_valid | input | 1 | Stream word present |
| s_ready | output | 1 | Engine takes a stream word this cycle |
| s_idx | input | IW | Row position inside its group (row words) |
| s_data | input | 8*LANES | Header count or per-lane weights |
| feat_addr | output | FA_W | Feature buffer read address |
| feat_data | input | 8 | Signed feature read at `feat_addr` |
| res_valid | output | 1 | Result pulse |
| res_data | output | ACC_W*LANES | Per-lane accumulators, lane 0 in the low bits |
| done | output | 1 | Pass complete pulse |

## Verification
The bench tries several kinds of group patterns. Fully dense groups (N = M) and fully empty groups (N = 0) pin down the two ends of the cycle formula. A sweep over every group count with random N per group, together with a one-group sweep over each N and each position rotation, shows whether the header count and the position tags steer the feature addressing correctly. The results are compared with a dense dot product in which the zeros are put back. Over-range header counts, gaps in `s_valid`, a start pulse in the middle of a pass, and runs of extreme products each check one rule separately: the count clamp, stall neutrality, start lockout and saturation direction.

// File: rtl/spmac_pkg.sv
package spmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_ROW  = 2'd2
  } spmac_st_e;
endpackage

// File: rtl/spmac_ctrl.sv
module spmac_ctrl
  import spmac_pkg::*;
#(
  parameter int M          = 4,
  parameter int MAX_GROUPS = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [$clog2(MAX_GROUPS+1)-1:0]     num_groups,
  input  logic                                s_valid,
  input  logic [$clog2(M+1)-1:0]              hdr_n,
  input  logic [((M>1)?$clog2(M):1)-1:0]      s_idx,
  output logic                                busy,
  output logic                                mac_en,
  output logic                                acc_clr,
  output logic                                fin,
  output logic [((MAX_GROUPS*M>1)?$clog2(MAX_GROUPS*M):1)-1:0] feat_addr
);
  localparam int NW   = $clog2(M+1);
  localparam int IW   = (M > 1) ? $clog2(M) : 1;
  localparam int GW   = $clog2(MAX_GROUPS+1);
  localparam int FA_W = (MAX_GROUPS*M > 1) ? $clog2(MAX_GROUPS*M) : 1;
  localparam logic [NW-1:0]   M_N   = NW'(M);
  localparam logic [NW-1:0]   ONE_N = NW'(1);
  localparam logic [GW-1:0]   ONE_G = GW'(1);
  localparam logic [FA_W-1:0] M_F   = FA_W'(M);

  spmac_st_e       st_q, st_d;
  logic [GW-1:0]   grp_q, grp_d;
  logic [GW-1:0]   ngrp_q, ngrp_d;
  logic [NW-1:0]   left_q, left_d;
  logic            fin_q, fin_d;
  logic            reg_en;
  logic            last_grp;
  logic [NW-1:0]   hdr_eff;

  assign hdr_eff  = (hdr_n > M_N) ? M_N : hdr_n;
  assign last_grp = ((grp_q + ONE_G) == ngrp_q);
  assign busy     = (st_q != ST_IDLE);
  assign mac_en   = (st_q == ST_ROW) && s_valid;
  assign feat_addr = FA_W'(grp_q) * M_F + FA_W'(s_idx);
  assign fin      = fin_q;
  assign reg_en   = busy || start;

  always_comb begin
    st_d    = st_q;
    grp_d   = grp_q;
    ngrp_d  = ngrp_q;
    left_d  = left_q;
    fin_d   = 1'b0;
    acc_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          acc_clr = 1'b1;
          ngrp_d  = num_groups;
          grp_d   = '0;
          if (num_groups == '0) fin_d = 1'b1;
          else                  st_d  = ST_HDR;
        end
      end
      ST_HDR: begin
        if (s_valid) begin
          if (hdr_eff == '0) begin
            if (last_grp) begin
              st_d  = ST_IDLE;
              fin_d = 1'b1;
            end else begin
              grp_d = grp_q + ONE_G;
            end
          end else begin
            left_d = hdr_eff;
            st_d   = ST_ROW;
          end
        end
      end
      ST_ROW: begin
        if (s_valid) begin
          left_d = left_q - ONE_N;
          if (left_q == ONE_N) begin
            if (last_grp) begin
              st_d  = ST_IDLE;
              fin_d = 1'b1;
            end else begin
              grp_d = grp_q + ONE_G;
              st_d  = ST_HDR;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      grp_q  <= '0;
      ngrp_q <= '0;
      left_q <= '0;
    end else if (reg_en) begin
      st_q   <= st_d;
      grp_q  <= grp_d;
      ngrp_q <= ngrp_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fin_q <= 1'b0;
    else        fin_q <= fin_d;
  end

  // R7: a missing stream word freezes the walk through the groups
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !s_valid) |=> ($stable(st_q) && $stable(grp_q) && $stable(left_q)));

  // R11: start while busy leaves the latched group count alone
  a_r11_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(ngrp_q));

  // R4: the last counted row always leaves the row phase
  a_r4_row_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ROW && s_valid && left_q == ONE_N) |=> (st_q != ST_ROW));

  // R5: an empty group never enters the row phase
  a_r5_empty_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR && s_valid && hdr_n == '0) |=> (st_q != ST_ROW));
endmodule

// File: rtl/spmac_lane.sv
module spmac_lane #(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [7:0]       w,
  input  logic signed [7:0]       x,
  output logic signed [ACC_W-1:0] acc
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [15:0]      prod;
  logic signed [ACC_W:0]   sum;
  logic signed [ACC_W-1:0] sat;
  logic signed [ACC_W-1:0] acc_q, acc_d;

  assign prod = w * x;
  assign sum  = {acc_q[ACC_W-1], acc_q} + {{(ACC_W-15){prod[15]}}, prod};

  always_comb begin
    if (sum[ACC_W] != sum[ACC_W-1]) sat = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    else                            sat = sum[ACC_W-1:0];
  end

  always_comb begin
    if (clr)     acc_d = '0;
    else if (en) acc_d = sat;
    else         acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (clr || en) acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R8: once at the top, positive products keep it pinned there
  a_r8_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && acc_q == ACC_MAX && prod > 16'sd0) |=> (acc_q == ACC_MAX));

  // R8: once at the bottom, negative products keep it pinned there
  a_r8_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && acc_q == ACC_MIN && prod < 16'sd0) |=> (acc_q == ACC_MIN));

  // R9: a clear always lands on zero
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/spmac_engine.sv
module spmac_engine
  import spmac_pkg::*;
#(
  parameter int M          = 4,
  parameter int LANES      = 4,
  parameter int ACC_W      = 32,
  parameter int MAX_GROUPS = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [$clog2(MAX_GROUPS+1)-1:0]       num_groups,
  output logic                                  busy,
  input  logic                                  s_valid,
  output logic                                  s_ready,
  input  logic [((M>1)?$clog2(M):1)-1:0]        s_idx,
  input  logic [8*LANES-1:0]                    s_data,
  output logic [((MAX_GROUPS*M>1)?$clog2(MAX_GROUPS*M):1)-1:0] feat_addr,
  input  logic [7:0]                            feat_data,
  output logic                                  res_valid,
  output logic [ACC_W*LANES-1:0]                res_data,
  output logic                                  done
);
  localparam int NW = $clog2(M+1);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       mac_en;
  logic       acc_clr;
  logic       fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  spmac_ctrl #(.M(M), .MAX_GROUPS(MAX_GROUPS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (start),
    .num_groups (num_groups),
    .s_valid    (s_valid),
    .hdr_n      (s_data[NW-1:0]),
    .s_idx      (s_idx),
    .busy       (busy),
    .mac_en     (mac_en),
    .acc_clr    (acc_clr),
    .fin        (fin),
    .feat_addr  (feat_addr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    spmac_lane #(.ACC_W(ACC_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n_i),
      .clr   (acc_clr),
      .en    (mac_en),
      .w     (s_data[8*l +: 8]),
      .x     (feat_data),
      .acc   (res_data[ACC_W*l +: ACC_W])
    );
  end

  assign s_ready   = busy;
  assign res_valid = fin;
  assign done      = fin;

  // R10: completion is reported only once the engine is idle again
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |-> !busy);

  // R10: without a fresh start the completion pulse lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done && !start) |=> !done);

  // R10: the sums stay put while no pass is running
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!busy && !start && $past(!busy)) |=> $stable(res_data));
endmodule

// File: tb/sim_spmac_engine.sv
`timescale 1ns/1ps
module sim_spmac_engine;
  localparam int M     = 4;
  localparam int LANES = 2;
  localparam int ACC_W = 18;
  localparam int MAXG  = 8;
  localparam int GW    = $clog2(MAXG+1);
  localparam int IW    = $clog2(M);
  localparam int FA_W  = $clog2(MAXG*M);
  localparam int NF    = MAXG*M;
  localparam int AMAX  = (1 << (ACC_W-1)) - 1;
  localparam int AMIN  = -(1 << (ACC_W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [GW-1:0] num_groups = '0;
  logic busy, s_ready, res_valid, done;
  logic s_valid = 1'b0;
  logic [IW-1:0] s_idx = '0;
  logic [8*LANES-1:0] s_data = '0;
  logic [FA_W-1:0] feat_addr;
  logic [7:0] feat_data;
  logic [ACC_W*LANES-1:0] res_data;

  always #2.5 clk = ~clk;

  spmac_engine #(.M(M), .LANES(LANES), .ACC_W(ACC_W), .MAX_GROUPS(MAXG)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .num_groups(num_groups), .busy(busy),
    .s_valid(s_valid), .s_ready(s_ready), .s_idx(s_idx), .s_data(s_data),
    .feat_addr(feat_addr), .feat_data(feat_data), .res_valid(res_valid),
    .res_data(res_data), .done(done)
  );

  logic [7:0] feat [0:NF-1];
  assign feat_data = feat[feat_addr];

  int checks = 0;
  int errors = 0;

  logic [8*LANES-1:0] sw_data [0:63];
  logic [IW-1:0]      sw_idx  [0:63];
  int                 sw_addr [0:63];
  int sw_len;
  int wd [0:NF-1][0:LANES-1];
  int n_total;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(input longint v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return int'(v);
  endfunction

  task automatic set_feats(input int flim, input int ffix);
    for (int a = 0; a < NF; a++)
      feat[a] = (flim == 0) ? 8'(ffix) : 8'($urandom_range(2*flim) - flim);
  endtask

  // mode 0: random N, 1: N=M, 2: N=0, 3: N=nfix; wfix!=0 forces every weight
  task automatic gen(input int ng, input int mode, input int nfix, input int wlim,
                     input int wfix, input bit over, input int rot);
    sw_len = 0;
    n_total = 0;
    for (int k = 0; k < NF; k++)
      for (int l = 0; l < LANES; l++) wd[k][l] = 0;
    for (int g = 0; g < ng; g++) begin
      int n;
      int perm [0:M-1];
      case (mode)
        0: n = $urandom_range(M);
        1: n = M;
        2: n = 0;
        default: n = nfix;
      endcase
      for (int i = 0; i < M; i++) perm[i] = (i + rot) % M;
      for (int i = M-1; i > 0; i--) begin
        int j = $urandom_range(i);
        int t = perm[i];
        if (rot == 0) begin perm[i] = perm[j]; perm[j] = t; end
      end
      sw_data[sw_len] = ((over && n == M) ? (8*LANES)'(M + 1 + (g % 3)) : (8*LANES)'(n));
      sw_idx[sw_len]  = IW'($urandom_range(M-1));
      sw_addr[sw_len] = -1;
      sw_len++;
      n_total += n;
      for (int r = 0; r < n; r++) begin
        for (int l = 0; l < LANES; l++) begin
          int w;
          if (wfix != 0) w = wfix;
          else begin
            w = $urandom_range(2*wlim - 1) - wlim;
            if (w >= 0) w++;
          end
          sw_data[sw_len][8*l +: 8] = 8'(w);
          wd[g*M + perm[r]][l] = w;
        end
        sw_idx[sw_len]  = IW'(perm[r]);
        sw_addr[sw_len] = g*M + perm[r];
        sw_len++;
      end
    end
  endtask

  task automatic run(input int ng, input bit stall, input bit poke, input bit dense,
                     input string tag);
    int ptr = 0;
    int cyc = 0;
    int gaps = 0;
    int iter = 0;
    bit fin_seen = 1'b0;
    bit poked = 1'b0;
    int got [0:LANES-1];
    int seq [0:LANES-1];
    longint den [0:LANES-1];
    @(negedge clk);
    start = 1'b1;
    num_groups = GW'(ng);
    while (!fin_seen && iter < 400) begin
      bit hs;
      @(negedge clk);
      iter++;
      start = 1'b0;
      if (done) begin
        fin_seen = 1'b1;
        chk(res_valid == 1'b1, "R10", {tag, " res_valid with done"}, res_valid, 1);
        for (int l = 0; l < LANES; l++) got[l] = int'($signed(res_data[ACC_W*l +: ACC_W]));
        s_valid = 1'b0;
      end else begin
        if (busy) cyc++;
        if (poke && !poked && ptr == 2) begin
          start = 1'b1;
          num_groups = GW'(1);
          poked = 1'b1;
        end
        if (ptr < sw_len && !(stall && ($urandom_range(2) == 0))) begin
          s_valid = 1'b1;
          s_data  = sw_data[ptr];
          s_idx   = sw_idx[ptr];
        end else begin
          s_valid = 1'b0;
          s_data  = (8*LANES)'($urandom);
          s_idx   = IW'($urandom);
          if (busy) gaps++;
        end
        hs = s_valid && s_ready;
        @(posedge clk);
        if (hs) ptr++;
      end
    end
    if (!fin_seen) begin
      chk(1'b0, "R10", {tag, " pass never completed"}, iter, 0);
      return;
    end
    for (int l = 0; l < LANES; l++) begin
      longint a = 0;
      seq[l] = 0;
      den[l] = 0;
      for (int p = 0; p < sw_len; p++)
        if (sw_addr[p] >= 0) begin
          a = longint'(seq[l]) + longint'($signed(sw_data[p][8*l +: 8])) *
              longint'($signed(feat[sw_addr[p]]));
          seq[l] = clampi(a);
        end
      for (int k = 0; k < ng*M; k++) den[l] += longint'(wd[k][l]) * longint'($signed(feat[k]));
      chk(got[l] == seq[l], "R1", {tag, $sformatf(" lane %0d sum", l)}, got[l], seq[l]);
      if (dense)
        chk(longint'(got[l]) == den[l], "R3", {tag, $sformatf(" lane %0d vs dense", l)},
            got[l], den[l]);
    end
    chk(cyc == ng + n_total + gaps, "R4", {tag, " busy cycles"}, cyc, ng + n_total + gaps);
    chk(ptr == sw_len, "R4", {tag, " words consumed"}, ptr, sw_len);
    @(negedge clk);
    chk(done == 1'b0 && res_valid == 1'b0, "R10", {tag, " pulse width"}, done, 0);
    for (int l = 0; l < LANES; l++)
      chk(int'($signed(res_data[ACC_W*l +: ACC_W])) == got[l], "R10",
          {tag, " result held"}, int'($signed(res_data[ACC_W*l +: ACC_W])), got[l]);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "R4", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_feats(60, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12: idle state after reset
    chk(busy == 1'b0 && s_ready == 1'b0, "R12", "busy/ready after reset", busy, 0);
    chk(done == 1'b0 && res_valid == 1'b0, "R12", "done after reset", done, 0);
    chk(res_data == '0, "R12", "accumulators after reset", res_data, 0);

    // R1 R4: every group dense
    gen(MAXG, 1, 0, 60, 0, 1'b0, 0);
    run(MAXG, 1'b0, 1'b0, 1'b1, "all-dense");

    // R9: zero groups after a nonzero pass must report zero
    gen(0, 0, 0, 60, 0, 1'b0, 0);
    run(0, 1'b0, 1'b0, 1'b1, "R9 zero-groups");

    // R5: every group empty
    gen(MAXG, 2, 0, 60, 0, 1'b0, 0);
    run(MAXG, 1'b0, 1'b0, 1'b1, "R5 all-empty");

    // R2 R3 R4: random N per group for every group count
    for (int ng = 1; ng <= MAXG; ng++)
      for (int rep = 0; rep < 5; rep++) begin
        set_feats(60, 0);
        gen(ng, 0, 0, 60, 0, 1'b0, 0);
        run(ng, 1'b0, 1'b0, 1'b1, $sformatf("R2 sweep g%0d", ng));
      end

    // R3: single group, every N, every position rotation
    for (int n = 0; n <= M; n++)
      for (int rot = 1; rot <= M; rot++) begin
        gen(1, 3, n, 60, 0, 1'b0, rot);
        run(1, 1'b0, 1'b0, 1'b1, $sformatf("R3 single n%0d r%0d", n, rot));
      end

    // R6: header counts above M behave as M
    gen(MAXG, 1, 0, 60, 0, 1'b1, 0);
    run(MAXG, 1'b0, 1'b0, 1'b1, "R6 over-count");

    // R7: random gaps in the stream
    for (int rep = 0; rep < 4; rep++) begin
      gen(MAXG, 0, 0, 60, 0, 1'b0, 0);
      run(MAXG, 1'b1, 1'b0, 1'b1, "R7 stalled");
    end

    // R8: positive and negative saturation
    set_feats(0, 127);
    gen(MAXG, 1, 0, 0, 127, 1'b0, 0);
    run(MAXG, 1'b0, 1'b0, 1'b0, "R8 sat-high");
    chk(int'($signed(res_data[ACC_W-1:0])) == AMAX, "R8", "clamped high",
        int'($signed(res_data[ACC_W-1:0])), AMAX);
    gen(MAXG, 1, 0, 0, -128, 1'b0, 0);
    run(MAXG, 1'b0, 1'b0, 1'b0, "R8 sat-low");
    chk(int'($signed(res_data[ACC_W-1:0])) == AMIN, "R8", "clamped low",
        int'($signed(res_data[ACC_W-1:0])), AMIN);

    // R11: start pulse in the middle of a pass is ignored
    set_feats(60, 0);
    gen(MAXG, 0, 0, 60, 0, 1'b0, 0);
    run(MAXG, 1'b0, 1'b1, 1'b1, "R11 mid-start");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule